// File: doc/BRIEF.md
# Control Endpoint Turnaround FIFO

This block is a single small byte queue that serves the default control endpoint of a USB device controller. It is shared by the processor and the device engine, and the device engine decides which way data flows. After reset, and after every new setup transaction, the queue is in receive direction. The engine streams the eight setup bytes from the host into it, and the processor pops them through a read strobe.

When the eighth setup byte is stored, the block looks at the direction bit of the first byte. If the host expects data back, the queue turns around into transmit direction. The processor may then push response bytes and marks the end of the packet with a strobe. After that strobe the engine drains the bytes over a ready/valid handshake. Once the queue is empty, the block falls back to receive direction with fresh pointers.

Writes outside a transmit window are refused. Simultaneous read and write strobes from the processor are refused. Pushes into a full queue and pops from an empty one are dropped. Each of these sets its own sticky flag, which clears only on reset.

Top module: `ctlEp0Fifo`

## Requirements
- R1: After reset the count is 0, empty is 1, full is 0, direction is receive (dirTx = 0), the read data is 0x00, and all four error flags are 0.
- R2: The read port always shows the oldest stored byte. A CPU read strobe removes that byte, so bytes leave in the order they were stored.
- R3: fifoCount reports occupancy 0..8, with fifoFull at 8 and fifoEmpty at 0. A push into a full queue is dropped and sets errOverflow. A read from an empty queue leaves the count unchanged and sets errUnderflow. Both flags are sticky.
- R4: A CPU read strobe and write strobe in the same cycle perform neither operation and set errCollision, which is sticky.
- R5: The cycle after the eighth setup byte is stored, setupDone is 1 for exactly one cycle. In that same cycle dirTx equals bit 7 of the first setup byte, where 1 means transmit.
- R6: A CPU write while in receive direction is ignored: count and contents are unchanged. It sets errWrDenied, which is sticky.
- R7: In transmit direction, CPU writes are appended at the newest position. engTxValid stays 0 until cpuPktEnd has been pulsed. After that pulse, engTxValid is 1 whenever the queue is not empty, engTxData shows the oldest byte, and each cycle with engTxValid and engTxReady both 1 removes one byte.
- R8: After cpuPktEnd, and until the block returns to receive direction, CPU writes are refused and CPU reads remove nothing.
- R9: When the queue is empty after cpuPktEnd, the next clock edge returns the block to receive direction. The next eight-byte setup is then decoded again.
- R10: setupStart has priority over every other input in its cycle. It empties the queue, resets the pointers, forces receive direction and cancels a pending end of packet.
- R11: If bit 7 of the first setup byte is 0, the block stays in receive direction after the eighth byte, and CPU writes remain refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuRdEn | input | 1 | CPU read strobe (pops the oldest byte) |
| cpuRdData | output | 8 | Oldest stored byte |
| cpuWrEn | input | 1 | CPU write strobe (pushes a byte) |
| cpuWrData | input | 8 | Byte to push from the CPU |
| cpuPktEnd | input | 1 | CPU marks the response packet complete |
| setupStart | input | 1 | Engine: new setup transaction, flush and go to receive direction |
| engRxValid | input | 1 | Engine: byte from the host is present |
| engRxData | input | 8 | Engine: byte from the host |
| setupDone | output | 1 | One-cycle pulse after the eighth setup byte is stored |
| engTxValid | output | 1 | A byte is available for the engine to send |
| engTxData | output | 8 | Byte for the engine to send |
| engTxReady | input | 1 | Engine accepts engTxData |
| fifoFull | output | 1 | Queue holds 8 bytes |
| fifoEmpty | output | 1 | Queue holds no byte |
| fifoCount | output | 4 | Occupancy |
| dirTx | output | 1 | 1 = transmit direction, 0 = receive direction |
| errOverflow | output | 1 | Sticky: a push was dropped because the queue was full |
| errUnderflow | output | 1 | Sticky: a read was attempted on an empty queue |
| errCollision | output | 1 | Sticky: read and write strobes arrived together |
| errWrDenied | output | 1 | Sticky: a CPU write was refused |

## Verification
The bench covers the following corner cases and the wrong behaviour each one would expose:
- A ninth host byte into a full queue. A wrong design would overwrite the oldest setup byte or wrap the count to zero.
- Read and write strobes together. A wrong design would pop or push anyway and corrupt the oldest byte.
- A setup whose first byte has bit 7 clear. A wrong design could still turn around and accept CPU writes.
- Writes and reads after the end-of-packet strobe. A wrong design could let the processor steal or append bytes while the engine drains.
- The return to receive direction after the last drained byte. A stuck design would never decode the next setup.
- setupStart arriving together with a write. A wrong design would let the write land in a queue that should be empty.

// File: rtl/ep0Pkg.sv
package ep0Pkg;
  // strobes from the control module to the datapath
  typedef struct packed {
    logic push;        // store one byte at the newest position
    logic pushFromCpu; // 1: byte from CPU, 0: byte from engine
    logic pop;         // drop the oldest byte
    logic flush;       // clear pointers and count
  } fifoCtl_t;
endpackage

// File: rtl/ep0Datapath.sv
module ep0Datapath
  import ep0Pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtl_t          ctl,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [DATA_W-1:0] engData,
  output logic [DATA_W-1:0] oldestByte,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [DATA_W-1:0] pushData;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pushData   = ctl.pushFromCpu ? cpuData : engData;
  assign oldestByte = mem[rdPtr];
  assign full       = (count == CNT_W'(DEPTH));
  assign empty      = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ctl.push && !ctl.flush) begin
      mem[wrPtr] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= nextPtr(wrPtr);
      if (ctl.pop)  rdPtr <= nextPtr(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.push && !ctl.pop && full));
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.pop && empty));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> empty);
endmodule

// File: rtl/ep0Ctrl.sv
module ep0Ctrl
  import ep0Pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SETUP_LEN = 8,
  parameter int DIR_BIT   = 7,
  localparam int SC_W     = $clog2(SETUP_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRdEn,
  input  logic              cpuWrEn,
  input  logic              cpuPktEnd,
  input  logic              setupStart,
  input  logic              engRxValid,
  input  logic [DATA_W-1:0] engRxByte,
  input  logic              engTxReady,
  input  logic              full,
  input  logic              empty,
  output fifoCtl_t          ctl,
  output logic              engTxValid,
  output logic              dirTx,
  output logic              setupDone,
  output logic              errOverflow,
  output logic              errUnderflow,
  output logic              errCollision,
  output logic              errWrDenied
);
  logic            txArmed;
  logic [SC_W-1:0] setupCnt;
  logic            dirBit;
  logic            collide, ovfEv, udfEv, denyEv, collEv, goIdle, rxAccept;
  logic            decideBit;

  assign collide    = cpuRdEn && cpuWrEn;
  assign engTxValid = dirTx && txArmed && !empty;
  assign decideBit  = (setupCnt == '0) ? engRxByte[DIR_BIT] : dirBit;

  always_comb begin
    ctl      = '0;
    ovfEv    = 1'b0;
    udfEv    = 1'b0;
    denyEv   = 1'b0;
    collEv   = 1'b0;
    goIdle   = 1'b0;
    rxAccept = 1'b0;
    if (setupStart) begin
      ctl.flush = 1'b1;
    end else begin
      collEv = collide;
      if (dirTx) begin
        if (txArmed) begin
          if (empty) begin
            goIdle    = 1'b1;
            ctl.flush = 1'b1;
          end else if (engTxReady) begin
            ctl.pop = 1'b1;
          end
          if (cpuWrEn && !collide) denyEv = 1'b1;
        end else begin
          if (cpuWrEn && !collide) begin
            if (full) ovfEv = 1'b1;
            else begin
              ctl.push        = 1'b1;
              ctl.pushFromCpu = 1'b1;
            end
          end
          if (cpuRdEn && !collide) begin
            if (empty) udfEv = 1'b1;
            else       ctl.pop = 1'b1;
          end
        end
      end else begin
        if (engRxValid) begin
          if (full) ovfEv = 1'b1;
          else begin
            ctl.push = 1'b1;
            rxAccept = 1'b1;
          end
        end
        if (cpuWrEn && !collide) denyEv = 1'b1;
        if (cpuRdEn && !collide) begin
          if (empty) udfEv = 1'b1;
          else       ctl.pop = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirTx        <= 1'b0;
      txArmed      <= 1'b0;
      setupCnt     <= '0;
      dirBit       <= 1'b0;
      setupDone    <= 1'b0;
      errOverflow  <= 1'b0;
      errUnderflow <= 1'b0;
      errCollision <= 1'b0;
      errWrDenied  <= 1'b0;
    end else begin
      setupDone    <= 1'b0;
      errOverflow  <= errOverflow  | ovfEv;
      errUnderflow <= errUnderflow | udfEv;
      errCollision <= errCollision | collEv;
      errWrDenied  <= errWrDenied  | denyEv;
      if (setupStart || goIdle) begin
        dirTx    <= 1'b0;
        txArmed  <= 1'b0;
        setupCnt <= '0;
      end else begin
        if (dirTx && !txArmed && cpuPktEnd) txArmed <= 1'b1;
        if (rxAccept && setupCnt < SC_W'(SETUP_LEN)) begin
          setupCnt <= setupCnt + 1'b1;
          if (setupCnt == '0) dirBit <= engRxByte[DIR_BIT];
          if (setupCnt == SC_W'(SETUP_LEN - 1)) begin
            setupDone <= 1'b1;
            dirTx     <= decideBit;
          end
        end
      end
    end
  end

  assert_wr_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && ctl.pushFromCpu) |-> (dirTx && !txArmed));
  assert_collision_R4: assert property (@(posedge clk) disable iff (!rstN)
    (collide && !dirTx) |-> (!ctl.pop && !(ctl.push && ctl.pushFromCpu)));
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    setupStart |=> (!dirTx && !txArmed));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |=> !setupDone);
  assert_drain_handshake_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pop && dirTx && txArmed) |-> engTxReady);
  assert_idle_return_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dirTx && txArmed && empty && !setupStart) |=> !dirTx);
endmodule

// File: rtl/ctlEp0Fifo.sv
module ctlEp0Fifo
  import ep0Pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  parameter int SETUP_LEN = 8,
  parameter int DIR_BIT   = 7,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRdEn,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuPktEnd,
  input  logic              setupStart,
  input  logic              engRxValid,
  input  logic [DATA_W-1:0] engRxData,
  output logic              setupDone,
  output logic              engTxValid,
  output logic [DATA_W-1:0] engTxData,
  input  logic              engTxReady,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              dirTx,
  output logic              errOverflow,
  output logic              errUnderflow,
  output logic              errCollision,
  output logic              errWrDenied
);
  fifoCtl_t          ctl;
  logic [DATA_W-1:0] oldestByte;

  assign cpuRdData = oldestByte;
  assign engTxData = oldestByte;

  ep0Ctrl #(
    .DATA_W(DATA_W), .SETUP_LEN(SETUP_LEN), .DIR_BIT(DIR_BIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cpuRdEn(cpuRdEn), .cpuWrEn(cpuWrEn), .cpuPktEnd(cpuPktEnd),
    .setupStart(setupStart), .engRxValid(engRxValid), .engRxByte(engRxData),
    .engTxReady(engTxReady), .full(fifoFull), .empty(fifoEmpty),
    .ctl(ctl), .engTxValid(engTxValid), .dirTx(dirTx), .setupDone(setupDone),
    .errOverflow(errOverflow), .errUnderflow(errUnderflow),
    .errCollision(errCollision), .errWrDenied(errWrDenied)
  );

  ep0Datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cpuData(cpuWrData), .engData(engRxData),
    .oldestByte(oldestByte), .full(fifoFull), .empty(fifoEmpty), .count(fifoCount)
  );

  assert_tx_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    engTxValid |-> (dirTx && !fifoEmpty));
endmodule

// File: tb/sim_ctlEp0Fifo.sv
module sim_ctlEp0Fifo;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuRdEn = 0, cpuWrEn = 0, cpuPktEnd = 0, setupStart = 0;
  logic       engRxValid = 0, engTxReady = 0;
  logic [7:0] cpuWrData = 0, engRxData = 0;
  logic [7:0] cpuRdData, engTxData;
  logic       setupDone, engTxValid, fifoFull, fifoEmpty, dirTx;
  logic       errOverflow, errUnderflow, errCollision, errWrDenied;
  logic [3:0] fifoCount;
  int         nTests = 0, nFails = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  ctlEp0Fifo u0 (
    .clk(clk), .rstN(rstN), .cpuRdEn(cpuRdEn), .cpuRdData(cpuRdData),
    .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData), .cpuPktEnd(cpuPktEnd),
    .setupStart(setupStart), .engRxValid(engRxValid), .engRxData(engRxData),
    .setupDone(setupDone), .engTxValid(engTxValid), .engTxData(engTxData),
    .engTxReady(engTxReady), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .fifoCount(fifoCount), .dirTx(dirTx), .errOverflow(errOverflow),
    .errUnderflow(errUnderflow), .errCollision(errCollision), .errWrDenied(errWrDenied)
  );

  task automatic chk(string tag, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic engPush(input logic [7:0] b);
    engRxValid = 1; engRxData = b; tick(); engRxValid = 0;
  endtask

  task automatic cpuWr(input logic [7:0] b);
    cpuWrEn = 1; cpuWrData = b; tick(); cpuWrEn = 0;
  endtask

  task automatic cpuRd(output logic [7:0] b);
    b = cpuRdData; cpuRdEn = 1; tick(); cpuRdEn = 0;
  endtask

  task automatic setupCmd(input logic [7:0] first);
    setupStart = 1; tick(); setupStart = 0;
    for (int i = 0; i < 8; i++) engPush(first + 8'(i));
  endtask

  task automatic t_reset();
    chk("R1 count", fifoCount, 0);
    chk("R1 empty", fifoEmpty, 1);
    chk("R1 full", fifoFull, 0);
    chk("R1 dirTx", dirTx, 0);
    chk("R1 rdData", cpuRdData, 0);
    chk("R1 errors", {errOverflow, errUnderflow, errCollision, errWrDenied}, 0);
  endtask

  task automatic t_rxCommand();
    logic [7:0] b;
    setupCmd(8'h21);
    chk("R5 setupDone pulse", setupDone, 1);
    chk("R11 stays receive", dirTx, 0);
    chk("R3 count full", fifoCount, 8);
    chk("R3 full flag", fifoFull, 1);
    tick();
    chk("R5 setupDone one cycle", setupDone, 0);
    cpuWr(8'hAA);
    chk("R6 write denied flag", errWrDenied, 1);
    chk("R6 count unchanged", fifoCount, 8);
    for (int i = 0; i < 8; i++) begin
      cpuRd(b);
      chk("R2 receive order", b, 8'h21 + i);
    end
    chk("R3 empty after drain", fifoEmpty, 1);
    cpuRd(b);
    chk("R3 underflow flag", errUnderflow, 1);
    chk("R3 count stays zero", fifoCount, 0);
  endtask

  task automatic t_overflowCollision();
    logic [7:0] b;
    setupCmd(8'h10);
    engPush(8'hEE);
    chk("R3 overflow flag", errOverflow, 1);
    chk("R3 count after overflow", fifoCount, 8);
    cpuRdEn = 1; cpuWrEn = 1; cpuWrData = 8'h99; tick(); cpuRdEn = 0; cpuWrEn = 0;
    chk("R4 collision flag", errCollision, 1);
    chk("R4 count unchanged", fifoCount, 8);
    chk("R4 oldest unchanged", cpuRdData, 8'h10);
    cpuRd(b);
    chk("R2 oldest first", b, 8'h10);
  endtask

  task automatic t_transmit();
    logic [7:0] b;
    setupCmd(8'h80);
    chk("R5 setupDone in", setupDone, 1);
    chk("R5 turn to transmit", dirTx, 1);
    for (int i = 0; i < 8; i++) begin
      cpuRd(b);
      chk("R2 setup read in tx", b, 8'h80 + i);
    end
    cpuWr(8'hA1); cpuWr(8'hB2); cpuWr(8'hC3);
    chk("R7 writes stored", fifoCount, 3);
    chk("R7 no drain before end", engTxValid, 0);
    cpuPktEnd = 1; tick(); cpuPktEnd = 0;
    chk("R7 valid after end", engTxValid, 1);
    chk("R7 oldest to engine", engTxData, 8'hA1);
    cpuWr(8'h55);
    chk("R8 write after end refused", fifoCount, 3);
    cpuRd(b);
    chk("R8 read after end no pop", fifoCount, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R7 drain valid", engTxValid, 1);
      chk("R7 drain data", engTxData, (i == 0) ? 8'hA1 : (i == 1) ? 8'hB2 : 8'hC3);
      engTxReady = 1; tick(); engTxReady = 0;
    end
    chk("R7 drained", fifoCount, 0);
    tick();
    chk("R9 back to receive", dirTx, 0);
    setupCmd(8'h80);
    chk("R9 next setup decoded", dirTx, 1);
  endtask

  task automatic t_abort();
    logic [7:0] b;
    cpuRd(b); cpuRd(b);
    cpuWr(8'h3C);
    chk("R7 tx write count", fifoCount, 7);
    setupStart = 1; cpuWrEn = 1; cpuWrData = 8'h77; tick();
    setupStart = 0; cpuWrEn = 0;
    chk("R10 flushed", fifoCount, 0);
    chk("R10 receive forced", dirTx, 0);
    chk("R10 empty", fifoEmpty, 1);
    engPush(8'h42);
    chk("R10 fresh pointers", cpuRdData, 8'h42);
    chk("R10 count one", fifoCount, 1);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    t_reset();
    t_rxCommand();
    t_overflowCollision();
    t_transmit();
    t_abort();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end
endmodule